// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol engine that sits between a two-wire serial bus and a 2048-byte memory array. It works inside a faster system clock. It oversamples the bus clock and data lines, filters them, and detects start and stop conditions. It receives a device address byte, a word address and data bytes. It acknowledges each byte by pulling the data line low through an open-drain enable. On reads it shifts out array data.

An internal 11-bit address counter serves byte writes, page writes, current-address reads, random reads and sequential reads. Written bytes are collected in a 16-byte page buffer. A valid stop hands the buffer to a separate commit unit. The commit unit copies the bytes into the array and then stays busy for a programmable write time. While the commit unit is busy, the engine does not acknowledge its device address, so a bus master can poll for the end of the write. The array is modelled as a synchronous RAM.

Top module: `twi_eeprom_engine`

## Requirements
- R1: A falling data line while the clock line is high is a start, and a rising data line while the clock is high is a stop. A start at any point, including the middle of a byte, clears the bit count and restarts reception of a device address.
- R2: The device address byte carries 1010 in bits [7:4] and the direction in bit 0 (1 = read, 0 = write). On any other value in bits [7:4], the engine gives no acknowledge and ignores all clocking until the next start.
- R3: For writes, bits [3:1] of the device address become address bits [10:8], and the next byte becomes bits [7:0]. Each accepted byte is acknowledged by driving the data line low during the ninth clock. The drive enable changes only while the filtered clock is low, or on a start or stop.
- R4: Data bytes of a write are acknowledged and collected. They are committed to the array only on a stop. The address advances in bits [3:0] only, so it wraps within the 16-byte page, and a later byte overwrites an earlier one at the same location.
- R5: While a write is being committed (copy plus write time), the device address is not acknowledged. After completion, it is acknowledged again.
- R6: A write-direction device address, with or without a word address, that is followed by a stop with no data byte starts no write cycle. A word address received this way still loads the counter.
- R7: Read data leaves MSB first and changes after the clock falls. After each byte, the counter increments and wraps from 2047 to 0. Output continues while the master acknowledges. After a master no-acknowledge, the line is released.
- R8: A read without a preceding word address starts at the last accessed address plus one. Bits [3:1] of a read-direction device address are ignored.
- R9: A pulse on either line that lasts fewer than FILT_LEN clock cycles has no effect. A filtered line changes only to a value that its synchronized input held on the preceding cycles.
- R10: Reset releases the data line, returns the engine to idle and clears the address counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (resolved wired-AND level) |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
A wrong engine state shows up at the data-line enable within one bus bit. Examples are a missing or extra acknowledge in the ninth clock, or read bits shifted by one position. A corrupted address counter or page buffer stays hidden until a later read. The bench therefore reads back every location it writes, around page and array boundaries. A commit unit that stays busy too long, or not at all, shows as a wrong acknowledge on the next polled device address, a few hundred clocks after the stop.

// File: rtl/twe_pkg.sv
package twe_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } eng_state_t;

  typedef enum logic [1:0] {
    CM_IDLE,
    CM_COPY,
    CM_HOLD
  } cmt_state_t;
endpackage

// File: rtl/twe_line_filter.sv
module twe_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic sync_o,
  output logic filt_o
);
  logic                meta_q, sync_q, filt_q, filt_n;
  logic [FILT_LEN-1:0] hist_q, hist_n;

  always_comb begin
    hist_n = {hist_q[FILT_LEN-2:0], sync_q};
    if (&hist_q)       filt_n = 1'b1;
    else if (~|hist_q) filt_n = 1'b0;
    else               filt_n = filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      hist_q <= hist_n;
      filt_q <= filt_n;
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/twe_array.sv
module twe_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/twe_commit.sv
module twe_commit
  import twe_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_i,
  input  logic [ADDR_W-PAGE_W-1:0]           row_i,
  input  logic [(1<<PAGE_W)-1:0]             mask_i,
  input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] buf_i,
  output logic                               busy_o,
  output logic                               we_o,
  output logic [ADDR_W-1:0]                  waddr_o,
  output logic [BYTE_W-1:0]                  wdata_o
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  cmt_state_t        st_q, st_n;
  logic [PAGE_W-1:0] idx_q, idx_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [PAGES-1:0]  mask_q, mask_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n;

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    row_n  = row_q;
    mask_n = mask_q;
    tmr_n  = tmr_q;
    case (st_q)
      CM_IDLE: begin
        if (req_i) begin
          row_n  = row_i;
          mask_n = mask_i;
          idx_n  = '0;
          st_n   = CM_COPY;
        end
      end
      CM_COPY: begin
        idx_n = idx_q + 1'b1;
        if (&idx_q) begin
          tmr_n = '0;
          st_n  = CM_HOLD;
        end
      end
      CM_HOLD: begin
        tmr_n = tmr_q + 1'b1;
        if (tmr_q == TMR_W'(WR_CYCLES - 1)) st_n = CM_IDLE;
      end
      default: st_n = CM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CM_IDLE;
      idx_q  <= '0;
      row_q  <= '0;
      mask_q <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      row_q  <= row_n;
      mask_q <= mask_n;
      tmr_q  <= tmr_n;
    end
  end

  assign busy_o  = (st_q != CM_IDLE);
  assign we_o    = (st_q == CM_COPY) && mask_q[idx_q];
  assign waddr_o = {row_q, idx_q};
  assign wdata_o = buf_i[idx_q];
endmodule

// File: rtl/twe_engine.sv
module twe_engine
  import twe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               scl_i,
  input  logic                               sda_i,
  input  logic                               busy_i,
  input  logic [BYTE_W-1:0]                  rd_data_i,
  output logic [ADDR_W-1:0]                  addr_o,
  output logic                               sda_oe_o,
  output logic                               start_o,
  output logic                               stop_o,
  output logic                               req_o,
  output logic [ADDR_W-PAGE_W-1:0]           req_row_o,
  output logic [(1<<PAGE_W)-1:0]             req_mask_o,
  output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] req_buf_o
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - BYTE_W;

  eng_state_t                     state_q, state_n, nxt_q, nxt_n;
  logic [2:0]                     bit_q, bit_n;
  logic [BYTE_W-1:0]              sh_q, sh_n;
  logic                           done_q, done_n;
  logic                           mack_q, mack_n;
  logic                           oe_q, oe_n;
  logic [ADDR_W-1:0]              addr_q, addr_n;
  logic [HI_W-1:0]                hi_q, hi_n;
  logic [PAGES-1:0]               mask_q, mask_n;
  logic [PAGES-1:0][BYTE_W-1:0]   buf_q, buf_n;
  logic                           scl_d_q, sda_d_q;
  logic                           scl_rise, scl_fall, start_evt, stop_evt;

  assign scl_rise  = scl_i & ~scl_d_q;
  assign scl_fall  = ~scl_i & scl_d_q;
  assign start_evt = scl_i & scl_d_q & sda_d_q & ~sda_i;
  assign stop_evt  = scl_i & scl_d_q & ~sda_d_q & sda_i;

  always_comb begin
    state_n = state_q;
    nxt_n   = nxt_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    done_n  = done_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    addr_n  = addr_q;
    hi_n    = hi_q;
    mask_n  = mask_q;
    buf_n   = buf_q;
    if (start_evt) begin
      state_n = ST_DEV;
      bit_n   = '0;
      done_n  = 1'b0;
      oe_n    = 1'b0;
      mask_n  = '0;
    end else if (stop_evt) begin
      state_n = ST_IDLE;
      done_n  = 1'b0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_i};
            bit_n = bit_q + 3'd1;
            if (bit_q == 3'd7) done_n = 1'b1;
          end
          if (scl_fall && done_q) begin
            done_n = 1'b0;
            if (state_q == ST_DEV) begin
              if (sh_q[7:4] == DEV_TAG && !busy_i) begin
                oe_n    = 1'b1;
                state_n = ST_ACK;
                if (sh_q[0]) begin
                  nxt_n = ST_RDATA;
                end else begin
                  nxt_n = ST_WADDR;
                  hi_n  = sh_q[HI_W:1];
                end
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              addr_n  = {hi_q, sh_q};
              oe_n    = 1'b1;
              nxt_n   = ST_WDATA;
              state_n = ST_ACK;
            end else begin
              buf_n[addr_q[PAGE_W-1:0]]  = sh_q;
              mask_n[addr_q[PAGE_W-1:0]] = 1'b1;
              addr_n  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              oe_n    = 1'b1;
              nxt_n   = ST_WDATA;
              state_n = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_n   = '0;
            state_n = nxt_q;
            if (nxt_q == ST_RDATA) begin
              sh_n = rd_data_i;
              oe_n = ~rd_data_i[7];
            end else begin
              oe_n = 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              oe_n    = 1'b0;
              addr_n  = addr_q + 1'b1;
              state_n = ST_RACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n  = ~sh_q[6];
              bit_n = bit_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_n = ~sda_i;
          if (scl_fall) begin
            if (mack_q) begin
              sh_n    = rd_data_i;
              oe_n    = ~rd_data_i[7];
              bit_n   = '0;
              state_n = ST_RDATA;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
      hi_q    <= '0;
      mask_q  <= '0;
      buf_q   <= '0;
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      state_q <= state_n;
      nxt_q   <= nxt_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      done_q  <= done_n;
      mack_q  <= mack_n;
      oe_q    <= oe_n;
      addr_q  <= addr_n;
      hi_q    <= hi_n;
      mask_q  <= mask_n;
      buf_q   <= buf_n;
      scl_d_q <= scl_i;
      sda_d_q <= sda_i;
    end
  end

  assign addr_o     = addr_q;
  assign sda_oe_o   = oe_q;
  assign start_o    = start_evt;
  assign stop_o     = stop_evt;
  assign req_o      = stop_evt & (|mask_q);
  assign req_row_o  = addr_q[ADDR_W-1:PAGE_W];
  assign req_mask_o = mask_q;
  assign req_buf_o  = buf_q;
endmodule

// File: rtl/twi_eeprom_engine.sv
module twi_eeprom_engine
  import twe_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int FILT_LEN  = 3,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_low_o
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [1:0] raw_w, sync_w, filt_w;
  logic       scl_f, sda_f, scl_s, sda_s;
  logic       start_w, stop_w, req_w, busy_w, we_w;
  logic [ADDR_W-1:0]              ctr_w, waddr_w, ram_addr_w;
  logic [ROW_W-1:0]               row_w;
  logic [PAGES-1:0]               mask_w;
  logic [PAGES-1:0][BYTE_W-1:0]   buf_w;
  logic [BYTE_W-1:0]              wdata_w, rdata_w;

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    twe_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_w[g]),
      .sync_o (sync_w[g]),
      .filt_o (filt_w[g])
    );
  end

  assign scl_f = filt_w[1];
  assign sda_f = filt_w[0];
  assign scl_s = sync_w[1];
  assign sda_s = sync_w[0];

  twe_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .busy_i     (busy_w),
    .rd_data_i  (rdata_w),
    .addr_o     (ctr_w),
    .sda_oe_o   (sda_drive_low_o),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .req_o      (req_w),
    .req_row_o  (row_w),
    .req_mask_o (mask_w),
    .req_buf_o  (buf_w)
  );

  twe_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_cmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_w),
    .row_i   (row_w),
    .mask_i  (mask_w),
    .buf_i   (buf_w),
    .busy_o  (busy_w),
    .we_o    (we_w),
    .waddr_o (waddr_w),
    .wdata_o (wdata_w)
  );

  assign ram_addr_w = busy_w ? waddr_w : ctr_w;

  twe_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (we_w),
    .addr_i  (ram_addr_w),
    .wdata_i (wdata_w),
    .rdata_o (rdata_w)
  );
endmodule

// File: rtl/twe_checker.sv
module twe_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_f,
  input logic scl_s,
  input logic sda_s,
  input logic start_w,
  input logic stop_w,
  input logic sda_oe,
  input logic busy_w,
  input logic req_w,
  input logic we_w
);
  // R9
  sda_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_f) |-> ($past(sda_s, 2) == sda_f) && ($past(sda_s, 3) == sda_f));

  // R9
  scl_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> ($past(scl_s, 2) == scl_f) && ($past(scl_s, 3) == scl_f));

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_f || $past(start_w || stop_w)));

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !sda_oe);

  // R4
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_w |-> !busy_w);

  // R4
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_w |-> busy_w);
endmodule

bind twi_eeprom_engine twe_checker chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_f),
  .sda_f   (sda_f),
  .scl_s   (scl_s),
  .sda_s   (sda_s),
  .start_w (start_w),
  .stop_w  (stop_w),
  .sda_oe  (sda_drive_low_o),
  .busy_w  (busy_w),
  .req_w   (req_w),
  .we_w    (we_w)
);

// File: tb/twi_eeprom_engine_tb_top.sv
module twi_eeprom_engine_tb_top;
  localparam int Q = 10;

  logic clk, rst_n, m_scl, m_sda, oe, sda_line;
  int   n_chk, n_fail;
  logic [7:0] rb [0:31];

  assign sda_line = m_sda & ~oe;

  twi_eeprom_engine dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (m_scl),
    .sda_i           (sda_line),
    .sda_drive_low_o (oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wait_q;
    m_scl = 1'b1; wait_q;
    m_sda = 1'b0; wait_q;
    m_scl = 1'b0; wait_q;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wait_q;
    m_scl = 1'b1; wait_q;
    m_sda = 1'b1; wait_q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wait_q;
      m_scl = 1'b1; wait_q; wait_q;
      m_scl = 1'b0; wait_q;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wait_q;
    m_scl = 1'b1; wait_q;
    ack = ~sda_line; wait_q;
    m_scl = 1'b0; wait_q;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wait_q;
      m_scl = 1'b1; wait_q;
      b[i] = sda_line; wait_q;
      m_scl = 1'b0; wait_q;
    end
    m_sda = ~give_ack; wait_q;
    m_scl = 1'b1; wait_q; wait_q;
    m_scl = 1'b0; wait_q;
    m_sda = 1'b1;
  endtask

  task automatic wait_idle(output int polls);
    logic ack;
    polls = 0;
    for (int k = 0; k < 60; k++) begin
      bus_start; send_byte(8'hA0, ack); bus_stop;
      if (ack) break;
      polls++;
    end
  endtask

  task automatic wr_seq(input logic [10:0] a, input int n, input logic [7:0] d0, input logic poll);
    logic ack;
    int   bad, polls;
    bad = 0;
    bus_start;
    send_byte({4'hA, a[10:8], 1'b0}, ack); if (!ack) bad++;
    send_byte(a[7:0], ack); if (!ack) bad++;
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i), ack); if (!ack) bad++;
    end
    bus_stop;
    check("R3 write bytes acknowledged", bad, 0);
    if (poll) wait_idle(polls);
  endtask

  task automatic rd_rand(input logic [10:0] a, input int n);
    logic ack;
    int   bad;
    bad = 0;
    bus_start;
    send_byte({4'hA, a[10:8], 1'b0}, ack); if (!ack) bad++;
    send_byte(a[7:0], ack); if (!ack) bad++;
    bus_start;
    send_byte(8'hA1, ack); if (!ack) bad++;
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rb[i]);
    bus_stop;
    check("R7 random read acknowledged", bad, 0);
  endtask

  task automatic rd_cur(input logic [7:0] dev, input int n);
    logic ack;
    bus_start;
    send_byte(dev, ack);
    check("R8 current read acknowledged", int'(ack), 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rb[i]);
    bus_stop;
  endtask

  task automatic t_reset;
    check("R10 drive released after reset", int'(oe), 0);
  endtask

  task automatic t_byte_write;
    logic ack;
    int   polls;
    wr_seq(11'h123, 1, 8'h5A, 1'b0);
    bus_start; send_byte(8'hA0, ack); bus_stop;
    check("R5 no ack while committing", int'(ack), 0);
    wait_idle(polls);
    check("R5 ack returns after commit", int'(polls < 59), 1);
    rd_rand(11'h123, 1);
    check("R4 byte write stored", rb[0], 8'h5A);
  endtask

  task automatic t_page_wrap;
    wr_seq(11'h2FE, 4, 8'h10, 1'b1);
    rd_rand(11'h2F0, 2);
    check("R4 page wrap slot 0", rb[0], 8'h12);
    check("R4 page wrap slot 1", rb[1], 8'h13);
    rd_rand(11'h2FE, 2);
    check("R4 page slot E", rb[0], 8'h10);
    check("R4 page slot F", rb[1], 8'h11);
  endtask

  task automatic t_seq_wrap;
    wr_seq(11'h7FF, 1, 8'hA7, 1'b1);
    wr_seq(11'h000, 2, 8'hC0, 1'b1);
    rd_rand(11'h7FF, 2);
    check("R7 last array byte", rb[0], 8'hA7);
    check("R7 wrap to address 0", rb[1], 8'hC0);
    check("R7 released after nack", int'(oe), 0);
    rd_cur(8'hAF, 1);
    check("R8 current read at last+1, page bits ignored", rb[0], 8'hC1);
  endtask

  task automatic t_bad_id;
    logic ack;
    bus_start;
    send_byte(8'hB0, ack);
    check("R2 wrong tag not acknowledged", int'(ack), 0);
    send_byte(8'hA0, ack);
    check("R2 ignored until next start", int'(ack), 0);
    bus_stop;
    rd_rand(11'h123, 1);
    check("R2 normal after wrong tag", rb[0], 8'h5A);
  endtask

  task automatic t_dummy;
    logic ack;
    bus_start; send_byte(8'hA2, ack); send_byte(8'h23, ack); bus_stop;
    bus_start; send_byte(8'hA0, ack); bus_stop;
    check("R6 no write cycle after address-only write", int'(ack), 1);
    rd_cur(8'hA1, 1);
    check("R6 counter loaded, data unchanged", rb[0], 8'h5A);
  endtask

  task automatic t_mid_start;
    logic ack;
    bus_start;
    send_bits(8'hA0, 4);
    bus_start;
    send_byte(8'hA2, ack);
    check("R1 start mid-byte restarts device address", int'(ack), 1);
    send_byte(8'h23, ack);
    bus_start;
    send_byte(8'hA1, ack);
    recv_byte(1'b0, rb[0]);
    bus_stop;
    check("R1 read after restarted byte", rb[0], 8'h5A);
  endtask

  task automatic t_glitch;
    logic ack;
    m_sda = 1'b0; @(posedge clk); #1; m_sda = 1'b1;
    wait_q;
    m_scl = 1'b0; wait_q;
    send_byte(8'hA1, ack);
    check("R9 short pulse is no start", int'(ack), 0);
    bus_stop;
  endtask

  task automatic t_overwrite;
    wr_seq(11'h040, 17, 8'h80, 1'b1);
    rd_rand(11'h040, 2);
    check("R4 17th byte overwrites slot 0", rb[0], 8'h90);
    check("R4 slot 1 kept", rb[1], 8'h81);
  endtask

  task automatic t_reset_ctr;
    rst_n = 1'b0; repeat (4) @(posedge clk); #1;
    rst_n = 1'b1; wait_q;
    check("R10 released after second reset", int'(oe), 0);
    rd_cur(8'hA1, 1);
    check("R10 counter cleared to 0", rb[0], 8'hC0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1;
    wait_q;
    t_reset;
    t_byte_write;
    t_page_wrap;
    t_seq_wrap;
    t_bad_id;
    t_dummy;
    t_mid_start;
    t_glitch;
    t_overwrite;
    t_reset_ctr;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule